// File: doc/BRIEF.md
# Banked Constant-Geometry NTT Engine

This block runs a complete number theoretic transform over a polynomial that sits in four external single-port memory banks. Each stage uses the same access pattern. Butterfly j reads the coefficients at indices j and j+n/2 and writes its two results to indices 2j and 2j+1. Because of this, one small counter drives every stage. Each coefficient is placed in a bank chosen by the top and bottom bits of its index. The butterflies are issued in an interleaved order, and the write-back of their results is deferred by one or two cycles. Together these let the engine start one butterfly per cycle and never give a bank more than one access in a cycle.

The data alternates between two pages of each bank: each stage reads one page and writes the other. The butterfly is the decimation-in-frequency form. The low output is u+v. The high output is (u−v)·w. The twiddle w comes from an external synchronous table addressed by `tw_idx`, and `tw_inv` tells that table which direction to use. Feeding inverse powers gives the inverse transform on the same hardware. Scaling by 1/n is left to a later pass. The result appears in bit-reversed order.

A host loads page 0 of the banks, pulses `start` with a length code, a modulus choice and a direction, and then waits for `done`.

Top module: `ntt_engine`

## Requirements
- R1: While reset is applied and after it is released, `busy` and `done` are low and no bank enable is asserted.
- R2: For length n = 2^L, coefficient index i is placed as follows.
  - The top bit is bit L−1 and the bottom bit is bit 0.
  - Top 0 with bottom 1 goes to bank 0. Top 0 with bottom 0 goes to bank 1. Top 1 with bottom 1 goes to bank 2. Top 1 with bottom 0 goes to bank 3.
  - The bank word address is {page, bits L−2..1 of i}, with the page as the address MSB.
  - Input is taken from page 0, and the result is left in page L mod 2.
- R3: With `tw_inv` low, the result at index i equals Σ x[m]·ω^(m·bitrev_L(i)) mod q. Here ω^k is the value the table returns for index k.
- R4: `tw_val` is sampled one cycle after `tw_idx` is presented, together with the bank read data of that same request. `tw_idx` is always below n/2.
- R5: In any cycle, no bank is both read and written, and every write cycle stores exactly two coefficients.
- R6: Length code 0 selects n=256, code 1 selects n=512, and codes 2 and 3 select n=1024.
- R7: `q_alt` = 0 selects modulus 12289 and `q_alt` = 1 selects 7681. Every stored result is below the selected modulus.
- R8: When `inverse` is high, `tw_inv` stays high for the whole run. The result is then Σ x[m]·ω^(−m·bitrev_L(i)) mod q, with no 1/n scaling.
- R9: `done` is a one-cycle pulse. It is seen exactly L·(n/2+3) rising edges after the edge that accepts `start`, and `busy` falls with it.
- R10: `start`, `len_code`, `q_alt` and `inverse` are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transform when idle |
| len_code | input | 2 | Transform length select |
| q_alt | input | 1 | Modulus select |
| inverse | input | 1 | Direction flag, forwarded to the twiddle table |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |
| tw_idx | output | LOGN_MAX−1 | Twiddle exponent request |
| tw_inv | output | 1 | Direction for the twiddle table |
| tw_val | input | 14 | Twiddle value, one cycle after request |
| bank_en | output | 4 | Per-bank access enable |
| bank_we | output | 4 | Per-bank write enable (read when low) |
| bank_addr | output | 4×(LOGN_MAX−1) | Per-bank word address |
| bank_wdata | output | 4×14 | Per-bank write data |
| bank_rdata | input | 4×14 | Per-bank read data, one cycle after a read |

## Verification
Each stage is n/2+3 cycles long:
- Reads are issued in stage cycles 0 to n/2−1.
- Each butterfly result is registered two cycles after its read.
- The two write pairs of group p are issued in stage cycles 2p+3 and 2p+4.

The bench does not probe these internal moments. It checks the outputs that the requirements fix:
- It counts rising edges from the accepting edge and requires `done` on exactly the L·(n/2+3)-th edge.
- It checks that `done` is low again one cycle later.
- It samples `tw_inv` a few cycles into the run.

Results are compared only after `done`, against a direct transform computed in the bench. All sampling happens on the falling clock edge, away from the edge that updates the design.

// File: rtl/ntt_pkg.sv
package ntt_pkg;

    localparam int COEF_W = 14;
    localparam int PROD_W = 2 * COEF_W;

    localparam logic [COEF_W:0] Q_MAIN = 15'd12289;
    localparam logic [COEF_W:0] Q_ALT  = 15'd7681;

    typedef logic [COEF_W-1:0] coef_t;

    // butterfly result: lo goes to the even index, hi to the odd index
    typedef struct packed {
        coef_t lo;
        coef_t hi;
    } pair_t;

    typedef enum logic {ST_IDLE, ST_RUN} run_state_t;

    typedef struct packed {
        logic [1:0] len_code;
        logic       q_alt;
        logic       inv;
    } cfg_t;

    function automatic logic [COEF_W:0] modulus(input logic alt);
        return alt ? Q_ALT : Q_MAIN;
    endfunction

    function automatic logic [3:0] log_len(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd8;
            2'd1:    return 4'd9;
            default: return 4'd10;
        endcase
    endfunction

    function automatic coef_t mod_add(input coef_t a, input coef_t b, input logic [COEF_W:0] q);
        logic [COEF_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= q) s = s - q;
        return coef_t'(s);
    endfunction

    function automatic coef_t mod_sub(input coef_t a, input coef_t b, input logic [COEF_W:0] q);
        logic [COEF_W:0] s;
        s = {1'b0, a} + q - {1'b0, b};
        if (s >= q) s = s - q;
        return coef_t'(s);
    endfunction

    // reduction by a constant per modulus, then a select
    function automatic coef_t mod_mul(input coef_t a, input coef_t b, input logic alt);
        logic [PROD_W-1:0] pr;
        logic [PROD_W-1:0] r0;
        logic [PROD_W-1:0] r1;
        pr = PROD_W'(a) * PROD_W'(b);
        r0 = pr % PROD_W'(Q_MAIN);
        r1 = pr % PROD_W'(Q_ALT);
        return alt ? coef_t'(r1) : coef_t'(r0);
    endfunction

    // bank number from index top bit and bottom bit
    function automatic logic [1:0] bank_of(input logic top, input logic bot);
        return {top, ~bot};
    endfunction

endpackage

// File: rtl/ntt_sched.sv
module ntt_sched
    import ntt_pkg::*;
#(
    parameter int LOGN_MAX = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [1:0]            len_code,
    input  logic                  q_alt_in,
    input  logic                  inv_in,
    output logic                  busy,
    output logic                  done,
    output logic                  q_alt,
    output logic                  inv,
    output logic                  page,
    output logic                  rd_en,
    output logic                  rd_lsb,
    output logic [LOGN_MAX-3:0]   rd_addr,
    output logic [LOGN_MAX-2:0]   tw_idx,
    output logic                  cap_en,
    output logic                  cap_slot,
    output logic                  cap_lsb,
    output logic                  wr_en,
    output logic                  wr_second,
    output logic                  wr_lsb,
    output logic [LOGN_MAX-3:0]   wr_addr
);

    localparam int CW = LOGN_MAX;
    localparam int IW = LOGN_MAX - 1;
    localparam int AI = LOGN_MAX - 2;
    localparam int SW = $clog2(LOGN_MAX);

    run_state_t     st;
    cfg_t           cfg;
    logic [SW-1:0]  stage;
    logic [CW-1:0]  cyc;

    logic [SW-1:0]  logn;
    logic [CW-1:0]  half_n, quart_n, last_cyc;
    logic [CW-1:0]  grp, jidx, pa, pb;
    logic           run, wa, wb;

    always_comb begin
        logn     = SW'(log_len(cfg.len_code));
        half_n   = CW'(1) << (logn - SW'(1));
        quart_n  = half_n >> 1;
        last_cyc = half_n + CW'(2);
        run      = (st == ST_RUN);
        grp      = cyc >> 1;
        jidx     = grp + (cyc[0] ? quart_n : '0);
        pa       = (cyc - CW'(3)) >> 1;
        pb       = (cyc - CW'(4)) >> 1;
        wa       = run && cyc[0]  && (cyc >= CW'(3)) && (cyc <= half_n + CW'(1));
        wb       = run && !cyc[0] && (cyc >= CW'(4)) && (cyc <= last_cyc);
    end

    assign busy      = run;
    assign q_alt     = cfg.q_alt;
    assign inv       = cfg.inv;
    assign page      = stage[0];
    assign rd_en     = run && (cyc < half_n);
    assign rd_lsb    = grp[0];
    assign rd_addr   = AI'(jidx >> 1);
    assign tw_idx    = IW'((jidx >> stage) << stage);
    assign wr_en     = wa || wb;
    assign wr_second = wb;
    assign wr_lsb    = wb ? ~pb[0] : pa[0];
    assign wr_addr   = wb ? AI'(pb) : AI'(pa);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cfg      <= '0;
            stage    <= '0;
            cyc      <= '0;
            done     <= 1'b0;
            cap_en   <= 1'b0;
            cap_slot <= 1'b0;
            cap_lsb  <= 1'b0;
        end else begin
            done     <= 1'b0;
            cap_en   <= rd_en;
            cap_slot <= cyc[0];
            cap_lsb  <= grp[0];
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        cfg   <= '{len_code: len_code, q_alt: q_alt_in, inv: inv_in};
                        stage <= '0;
                        cyc   <= '0;
                        st    <= ST_RUN;
                    end
                end
                default: begin
                    if (cyc == last_cyc) begin
                        cyc <= '0;
                        if (stage == logn - SW'(1)) begin
                            st   <= ST_IDLE;
                            done <= 1'b1;
                        end else begin
                            stage <= stage + SW'(1);
                        end
                    end else begin
                        cyc <= cyc + CW'(1);
                    end
                end
            endcase
        end
    end

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg));

    a_r4_tw_range: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (CW'(tw_idx) < half_n));

endmodule

// File: rtl/ntt_bfly.sv
module ntt_bfly
    import ntt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap_en,
    input  logic  cap_slot,
    input  logic  q_alt,
    input  coef_t u,
    input  coef_t v,
    input  coef_t w,
    output pair_t ga,
    output pair_t gb
);

    logic [COEF_W:0] q;
    pair_t           res;

    always_comb begin
        q      = modulus(q_alt);
        res.lo = mod_add(u, v, q);
        res.hi = mod_mul(mod_sub(u, v, q), w, q_alt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ga <= '0;
            gb <= '0;
        end else if (cap_en) begin
            if (cap_slot) gb <= res;
            else          ga <= res;
        end
    end

    a_r7_slot0_reduced: assert property (@(posedge clk) disable iff (rst)
        (cap_en && !cap_slot) |=> ({1'b0, ga.lo} < q && {1'b0, ga.hi} < q));

    a_r7_slot1_reduced: assert property (@(posedge clk) disable iff (rst)
        (cap_en && cap_slot) |=> ({1'b0, gb.lo} < q && {1'b0, gb.hi} < q));

endmodule

// File: rtl/ntt_bank_xbar.sv
module ntt_bank_xbar
    import ntt_pkg::*;
#(
    parameter int LOGN_MAX = 10
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                page,
    input  logic                                rd_en,
    input  logic                                rd_lsb,
    input  logic [LOGN_MAX-3:0]                 rd_addr,
    input  logic                                cap_lsb,
    input  logic                                wr_en,
    input  logic                                wr_second,
    input  logic                                wr_lsb,
    input  logic [LOGN_MAX-3:0]                 wr_addr,
    input  pair_t                               ga,
    input  pair_t                               gb,
    input  logic [3:0][COEF_W-1:0]              bank_rdata,
    output logic [3:0]                          bank_en,
    output logic [3:0]                          bank_we,
    output logic [3:0][LOGN_MAX-2:0]            bank_addr,
    output logic [3:0][COEF_W-1:0]              bank_wdata,
    output coef_t                               u,
    output coef_t                               v
);

    logic [3:0] rd_mask, wr_mask;
    coef_t      pend_top0, pend_top1;
    coef_t      wval0, wval1;

    always_comb begin
        rd_mask = '0;
        wr_mask = '0;
        if (rd_en) begin
            rd_mask[bank_of(1'b0, rd_lsb)] = 1'b1;
            rd_mask[bank_of(1'b1, rd_lsb)] = 1'b1;
        end
        if (wr_en) begin
            wr_mask[bank_of(1'b0, wr_lsb)] = 1'b1;
            wr_mask[bank_of(1'b1, wr_lsb)] = 1'b1;
        end
        if (wr_second) begin
            wval0 = pend_top0;
            wval1 = pend_top1;
        end else begin
            wval0 = wr_lsb ? ga.hi : ga.lo;
            wval1 = wr_lsb ? gb.hi : gb.lo;
        end
        u = bank_rdata[bank_of(1'b0, cap_lsb)];
        v = bank_rdata[bank_of(1'b1, cap_lsb)];
    end

    // hold the half of each result that is not stored in the first write
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_top0 <= '0;
            pend_top1 <= '0;
        end else if (wr_en && !wr_second) begin
            pend_top0 <= wr_lsb ? ga.lo : ga.hi;
            pend_top1 <= wr_lsb ? gb.lo : gb.hi;
        end
    end

    for (genvar b = 0; b < 4; b++) begin : g_bank
        assign bank_en[b]    = rd_mask[b] | wr_mask[b];
        assign bank_we[b]    = wr_mask[b];
        assign bank_addr[b]  = wr_mask[b] ? {~page, wr_addr} : {page, rd_addr};
        assign bank_wdata[b] = (b >= 2) ? wval1 : wval0;
    end

    a_r5_no_bank_clash: assert property (@(posedge clk) disable iff (rst)
        (rd_mask & wr_mask) == 4'b0);

    a_r5_write_pair: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($countones(bank_we) == 2));

endmodule

// File: rtl/ntt_engine.sv
module ntt_engine
    import ntt_pkg::*;
#(
    parameter int LOGN_MAX = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [1:0]                  len_code,
    input  logic                        q_alt,
    input  logic                        inverse,
    output logic                        busy,
    output logic                        done,
    output logic [LOGN_MAX-2:0]         tw_idx,
    output logic                        tw_inv,
    input  logic [COEF_W-1:0]           tw_val,
    output logic [3:0]                  bank_en,
    output logic [3:0]                  bank_we,
    output logic [3:0][LOGN_MAX-2:0]    bank_addr,
    output logic [3:0][COEF_W-1:0]      bank_wdata,
    input  logic [3:0][COEF_W-1:0]      bank_rdata
);

    localparam int AI = LOGN_MAX - 2;

    logic          q_sel, page, rd_en, rd_lsb, cap_en, cap_slot, cap_lsb;
    logic          wr_en, wr_second, wr_lsb;
    logic [AI-1:0] rd_addr, wr_addr;
    pair_t         ga, gb;
    coef_t         u, v;

    ntt_sched #(.LOGN_MAX(LOGN_MAX)) u_sched (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .len_code  (len_code),
        .q_alt_in  (q_alt),
        .inv_in    (inverse),
        .busy      (busy),
        .done      (done),
        .q_alt     (q_sel),
        .inv       (tw_inv),
        .page      (page),
        .rd_en     (rd_en),
        .rd_lsb    (rd_lsb),
        .rd_addr   (rd_addr),
        .tw_idx    (tw_idx),
        .cap_en    (cap_en),
        .cap_slot  (cap_slot),
        .cap_lsb   (cap_lsb),
        .wr_en     (wr_en),
        .wr_second (wr_second),
        .wr_lsb    (wr_lsb),
        .wr_addr   (wr_addr)
    );

    ntt_bfly u_bfly (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .cap_slot (cap_slot),
        .q_alt    (q_sel),
        .u        (u),
        .v        (v),
        .w        (tw_val),
        .ga       (ga),
        .gb       (gb)
    );

    ntt_bank_xbar #(.LOGN_MAX(LOGN_MAX)) u_xbar (
        .clk        (clk),
        .rst        (rst),
        .page       (page),
        .rd_en      (rd_en),
        .rd_lsb     (rd_lsb),
        .rd_addr    (rd_addr),
        .cap_lsb    (cap_lsb),
        .wr_en      (wr_en),
        .wr_second  (wr_second),
        .wr_lsb     (wr_lsb),
        .wr_addr    (wr_addr),
        .ga         (ga),
        .gb         (gb),
        .bank_rdata (bank_rdata),
        .bank_en    (bank_en),
        .bank_we    (bank_we),
        .bank_addr  (bank_addr),
        .bank_wdata (bank_wdata),
        .u          (u),
        .v          (v)
    );

    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bank_en == 4'b0));

endmodule

// File: tb/ntt_engine_test.sv
`timescale 1ns/100ps
module ntt_engine_test;
    import ntt_pkg::*;

    localparam int LOGN_MAX = 10;
    localparam int AW = LOGN_MAX - 1;
    localparam int PAGE_WORDS = 1 << (AW - 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [1:0] len_code = 2'd0;
    logic q_alt = 1'b0;
    logic inverse = 1'b0;
    logic busy, done, tw_inv;
    logic [AW-1:0] tw_idx;
    coef_t tw_val;
    logic [3:0] bank_en, bank_we;
    logic [3:0][AW-1:0] bank_addr;
    logic [3:0][COEF_W-1:0] bank_wdata;
    logic [3:0][COEF_W-1:0] bank_rdata;

    coef_t mem [4][1 << AW];
    coef_t twf [512];
    coef_t twi [512];
    longint pw [1024];
    longint xin [1024];

    int tests = 0;
    int fails = 0;
    longint cycles = 0;

    always #2.5 clk = ~clk;

    ntt_engine #(.LOGN_MAX(LOGN_MAX)) uut (
        .clk(clk), .rst(rst), .start(start), .len_code(len_code),
        .q_alt(q_alt), .inverse(inverse), .busy(busy), .done(done),
        .tw_idx(tw_idx), .tw_inv(tw_inv), .tw_val(tw_val),
        .bank_en(bank_en), .bank_we(bank_we), .bank_addr(bank_addr),
        .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
    );

    // synchronous single-port bank models
    always @(posedge clk) begin
        for (int b = 0; b < 4; b++) begin
            if (bank_en[b]) begin
                if (bank_we[b]) mem[b][bank_addr[b]] <= bank_wdata[b];
                else            bank_rdata[b] <= mem[b][bank_addr[b]];
            end
        end
    end

    // synchronous twiddle table
    always @(posedge clk) tw_val <= tw_inv ? twi[tw_idx] : twf[tw_idx];

    always @(posedge clk) cycles <= cycles + 1;

    task automatic chk(input bit ok, input string req, input longint act,
                       input longint exp, input string what);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint powmod(input longint b, input longint e, input longint q);
        longint r = 1;
        longint x = b % q;
        longint k = e;
        while (k > 0) begin
            if (k[0]) r = (r * x) % q;
            x = (x * x) % q;
            k = k >> 1;
        end
        return r;
    endfunction

    function automatic int bitrev(input int i, input int l);
        int r = 0;
        for (int k = 0; k < l; k++) r = (r << 1) | ((i >> k) & 1);
        return r;
    endfunction

    // code: length code driven; l: log2 length it must mean (R6)
    task automatic run_case(input int code, input int l, input bit qa, input bit iv,
                            input int pat, input bit poke);
        longint q, w, n, exp_v, act_v;
        longint edges, want;
        int page, bk, ad;
        bit seen;
        q = qa ? 7681 : 12289;
        n = 1 << l;
        w = 1;
        for (int g = 2; g < 100; g++) begin
            w = powmod(g, (q - 1) / n, q);
            if (powmod(w, n / 2, q) != 1) break;
        end
        for (int k = 0; k < n; k++) pw[k] = powmod(w, k, q);
        for (int k = 0; k < n / 2; k++) begin
            twf[k] = coef_t'(pw[k]);
            twi[k] = coef_t'(pw[(n - k) % n]);
        end
        for (int i = 0; i < n; i++) begin
            case (pat)
                0:       xin[i] = longint'($urandom % q);
                1:       xin[i] = q - 1;
                default: xin[i] = (i * 37 + 5) % q;
            endcase
            bk = (((i >> (l - 1)) & 1) << 1) | (~i & 1);
            ad = (i >> 1) & ((n / 4) - 1);
            mem[bk][ad] = coef_t'(xin[i]);
        end

        @(negedge clk);
        len_code = 2'(code);
        q_alt = qa;
        inverse = iv;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9", busy, 1, "busy after start");
        edges = 0;
        seen = 1'b0;
        while (!seen && edges < 20000) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (done) seen = 1'b1;
            if (edges == 5) chk(tw_inv == iv, "R8", tw_inv, iv, "direction to twiddle table");
            if (poke && edges == 40) begin
                // R10: a second start with other settings mid-run
                start = 1'b1;
                len_code = 2'd0;
                q_alt = ~qa;
                inverse = ~iv;
            end
            if (poke && edges == 41) start = 1'b0;
        end
        want = l * (n / 2 + 3);
        chk(seen && edges == want, "R9", edges, want, "edges to done");
        chk(busy == 1'b0, "R9", busy, 0, "busy with done");
        @(negedge clk);
        chk(done == 1'b0, "R9", done, 0, "done one cycle only");

        // R2/R3/R4/R5/R7/R8: compare against a direct transform
        page = l & 1;
        for (int i = 0; i < n; i++) begin
            int kk;
            kk = bitrev(i, l);
            exp_v = 0;
            for (int m = 0; m < n; m++) begin
                longint e;
                e = (longint'(m) * kk) % n;
                if (iv) e = (n - e) % n;
                exp_v = (exp_v + xin[m] * pw[e]) % q;
            end
            bk = (((i >> (l - 1)) & 1) << 1) | (~i & 1);
            ad = page * PAGE_WORDS + ((i >> 1) & ((n / 4) - 1));
            act_v = longint'(mem[bk][ad]);
            chk(act_v == exp_v, iv ? "R8" : "R3", act_v, exp_v, "coefficient (R2 R4 R5 R7)");
        end
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            chk(!busy && !done && bank_en == 4'b0, "R1", {busy, done, bank_en}, 0, "in reset");
        end
        rst = 1'b0;
        repeat (2) begin
            @(negedge clk);
            chk(!busy && !done && bank_en == 4'b0, "R1", {busy, done, bank_en}, 0, "after reset");
        end
        run_case(0, 8,  1'b1, 1'b0, 0, 1'b0);   // R6 code 0, R7 alt modulus
        run_case(1, 9,  1'b1, 1'b0, 2, 1'b0);   // R6 code 1
        run_case(2, 10, 1'b0, 1'b0, 0, 1'b0);   // R6 code 2
        run_case(0, 8,  1'b0, 1'b0, 1, 1'b0);   // all q-1 inputs, wrap in add/sub
        run_case(0, 8,  1'b0, 1'b1, 0, 1'b0);   // R8 inverse
        run_case(1, 9,  1'b0, 1'b1, 0, 1'b1);   // R10 start ignored while busy
        run_case(3, 10, 1'b0, 1'b0, 2, 1'b0);   // R6 code 3
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        tests++;
        fails++;
        $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule